// File: doc/BRIEF.md
# Slot-Timed Shared Lookup-Memory Arbiter

This block lets several look-up engines share a single program SRAM and a single ternary CAM. There is no request/grant handshake. A free-running owner counter splits time into slots, one clock per slot, with one slot for each engine. An engine may only move its own control state during its own slot. An engine may only touch the SRAM in its own slot, and only while it is in a phase that reads program memory.

Starting a CAM search takes a load phase lasting one full round of slots. An engine may enter that phase only if no other engine is in it at that moment. If the CAM is taken, the engine parks in a waiting state and tries again at its next slot.

Each engine runs through its own state machine: asleep (`SLEEP`), parked (`WAIT`), loading the CAM key (`LOAD`), two search-latency phases (`LAT1`, `LAT2`), and instruction execution (`COMP`). The `LAT2` phase includes the SRAM read of the search result. The transitions are:
- `SLEEP→LOAD` and `SLEEP→WAIT`, on new work.
- `WAIT→LOAD`, once the CAM is free.
- The fixed chain `LOAD→LAT1→LAT2→COMP`.
- From `COMP`: `COMP→COMP` for another instruction, `COMP→LOAD` or `COMP→WAIT` for a new CAM search, and `COMP→SLEEP` when the program ends.

The surrounding engines supply three per-engine inputs: work ready, more instructions, and a new search request. They use the SRAM and CAM strobes this block produces.

Top module: `lookup_slot_arbiter`

## Requirements
- R1: `slot_o` is 0 after reset. It rises by one on every clock and wraps from N_REQ-1 (3 by default) to 0.
- R2: Engine i samples its inputs and changes state only on a clock edge where `slot_o` equals i. Requests presented in other slots are ignored.
- R3: During and after reset, every engine is in `SLEEP`, so `cam_load`, `waiting` and `sram_gnt` are all zero.
- R4: In `SLEEP` during its slot with `work_req[i]`=1, an engine goes to `LOAD` if no engine is in `LOAD`, and to `WAIT` otherwise. With `work_req[i]`=0 it stays in `SLEEP`, and `more_req` and `cam_req` have no effect there.
- R5: In `WAIT`, an engine moves to `LOAD` at its first own slot in which no engine is in `LOAD`. Until then it stays in `WAIT`, and `waiting[i]`=1 exactly in that state.
- R6: `LOAD`, `LAT1` and `LAT2` each last one full round of N_REQ clocks, in that order, and are followed by `COMP`. `cam_load[i]`=1 exactly while engine i is in `LOAD`.
- R7: In `COMP` during its slot, `cam_req[i]`=1 leads to `LOAD` (CAM free) or `WAIT` (CAM in use), whatever `more_req[i]` is. Otherwise `more_req[i]`=1 keeps `COMP`, and if neither is set the engine goes to `SLEEP`.
- R8: `sram_gnt[i]`=1 exactly when `slot_o` equals i and engine i is in `LAT2` or `COMP`.
- R9: At most one bit of `cam_load` is set in any cycle. An engine enters `LOAD` only from a cycle in which no bit of `cam_load` was set.
- R10: No engine stays in `WAIT` for more than 3·N_REQ consecutive clocks (12 by default).
- R11: At most one bit of `sram_gnt` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| work_req | input | N_REQ | Per engine: a new header is ready to process |
| more_req | input | N_REQ | Per engine: another instruction follows (read in `COMP`) |
| cam_req | input | N_REQ | Per engine: program needs a new CAM search (read in `COMP`) |
| slot_o | output | SLOT_W | Current owner slot |
| sram_gnt | output | N_REQ | Per engine: SRAM access strobe this cycle |
| cam_load | output | N_REQ | Per engine: engine is loading the CAM key |
| waiting | output | N_REQ | Per engine: engine is parked waiting for the CAM |

## Verification
The checker watches every cycle for these properties:
- Exclusive CAM loading, and exclusive SRAM strobes that match the owner slot.
- Loading that starts only from a CAM-idle cycle.
- No change to an engine's visible state outside its slot.
- The waiting bound, counted with a per-engine counter.

The exact transition taken (sleep versus wait versus load, the `COMP` choices and their priority) and the length of each phase are covered only by the bench scenarios. These are a cycle-exact vector walk, a four-way contention run that measures the longest wait, and a test of requests shown outside their slot.

// File: rtl/lookup_slot_arbiter_pkg.sv
package lookup_slot_arbiter_pkg;

    // Per-engine control phase
    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_WAIT  = 3'd1,
        ST_LOAD  = 3'd2,
        ST_LAT1  = 3'd3,
        ST_LAT2  = 3'd4,
        ST_COMP  = 3'd5
    } lup_state_e;

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
    parameter int N_SLOT = 4,
    localparam int SW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] slot
);
    localparam logic [SW-1:0] LAST = SW'(N_SLOT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot <= '0;
        else if (slot == LAST)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end
endmodule

// File: rtl/lup_phase_fsm.sv
module lup_phase_fsm
    import lookup_slot_arbiter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       my_turn,
    input  logic       cam_busy,
    input  logic       work_req,
    input  logic       more_req,
    input  logic       cam_req,
    output lup_state_e state_o,
    output logic       sram_gnt_o,
    output logic       cam_load_o,
    output logic       waiting_o
);
    lup_state_e st_q, st_d;

    // State register: moves only in the owner slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_SLEEP;
        else if (my_turn)
            st_q <= st_d;
    end

    // Next-state choice
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SLEEP: begin
                if (work_req)
                    st_d = cam_busy ? ST_WAIT : ST_LOAD;
            end
            ST_WAIT: begin
                if (!cam_busy)
                    st_d = ST_LOAD;
            end
            ST_LOAD: st_d = ST_LAT1;
            ST_LAT1: st_d = ST_LAT2;
            ST_LAT2: st_d = ST_COMP;
            ST_COMP: begin
                if (cam_req)
                    st_d = cam_busy ? ST_WAIT : ST_LOAD;
                else if (more_req)
                    st_d = ST_COMP;
                else
                    st_d = ST_SLEEP;
            end
            default: st_d = ST_SLEEP;
        endcase
    end

    // Outputs
    always_comb begin
        state_o    = st_q;
        cam_load_o = (st_q == ST_LOAD);
        waiting_o  = (st_q == ST_WAIT);
        sram_gnt_o = my_turn && ((st_q == ST_LAT2) || (st_q == ST_COMP));
    end
endmodule

// File: rtl/lookup_slot_arbiter.sv
module lookup_slot_arbiter
    import lookup_slot_arbiter_pkg::*;
#(
    parameter int N_REQ = 4,
    localparam int SLOT_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  work_req,
    input  logic [N_REQ-1:0]  more_req,
    input  logic [N_REQ-1:0]  cam_req,
    output logic [SLOT_W-1:0] slot_o,
    output logic [N_REQ-1:0]  sram_gnt,
    output logic [N_REQ-1:0]  cam_load,
    output logic [N_REQ-1:0]  waiting
);
    logic [SLOT_W-1:0] slot;
    logic              cam_busy;
    logic [N_REQ-1:0]  turn;
    lup_state_e        phase [N_REQ];

    slot_timer #(.N_SLOT(N_REQ)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    // CAM is in use whenever some engine is in its load phase
    assign cam_busy = |cam_load;
    assign slot_o   = slot;

    for (genvar g = 0; g < N_REQ; g++) begin : g_lup
        assign turn[g] = (slot == SLOT_W'(g));

        lup_phase_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .my_turn    (turn[g]),
            .cam_busy   (cam_busy),
            .work_req   (work_req[g]),
            .more_req   (more_req[g]),
            .cam_req    (cam_req[g]),
            .state_o    (phase[g]),
            .sram_gnt_o (sram_gnt[g]),
            .cam_load_o (cam_load[g]),
            .waiting_o  (waiting[g])
        );
    end
endmodule

// File: rtl/lookup_slot_arbiter_chk.sv
module lookup_slot_arbiter_chk #(
    parameter int N_REQ = 4,
    localparam int SLOT_W = (N_REQ > 1) ? $clog2(N_REQ) : 1,
    localparam int WAIT_MAX = 3 * N_REQ,
    localparam int CW = $clog2(WAIT_MAX + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SLOT_W-1:0] slot_o,
    input logic [N_REQ-1:0]  sram_gnt,
    input logic [N_REQ-1:0]  cam_load,
    input logic [N_REQ-1:0]  waiting
);
    // R9: single loader of the CAM
    a_r9_cam_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cam_load));

    // R11: single SRAM user
    a_r11_sram_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sram_gnt));

    for (genvar i = 0; i < N_REQ; i++) begin : g_chk
        logic [CW-1:0] wait_cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                wait_cnt <= '0;
            else if (waiting[i] && wait_cnt <= CW'(WAIT_MAX))
                wait_cnt <= wait_cnt + 1'b1;
            else if (!waiting[i])
                wait_cnt <= '0;
        end

        // R10: bounded wait for the CAM
        a_r10_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
            wait_cnt <= CW'(WAIT_MAX));

        // R8: SRAM strobe only in the owner slot
        a_r8_sram_owner: assert property (@(posedge clk) disable iff (!rst_n)
            sram_gnt[i] |-> (slot_o == SLOT_W'(i)));

        // R2: visible state frozen unless the previous slot was this engine's
        a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(slot_o) != SLOT_W'(i)) |-> ($stable(cam_load[i]) && $stable(waiting[i])));

        // R9: loading starts only from an idle CAM
        a_r9_load_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cam_load[i]) |-> ($past(cam_load) == '0));
    end
endmodule

bind lookup_slot_arbiter lookup_slot_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_o   (slot_o),
    .sram_gnt (sram_gnt),
    .cam_load (cam_load),
    .waiting  (waiting)
);

// File: tb/lookup_slot_arbiter_test.sv
module lookup_slot_arbiter_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] work_req = '0, more_req = '0, cam_req = '0;
    logic [1:0]   slot_o;
    logic [N-1:0] sram_gnt, cam_load, waiting;

    int n_tests = 0;
    int n_fail  = 0;
    int t_edges = 0;

    always #10 clk = ~clk;  // 50 MHz

    lookup_slot_arbiter #(.N_REQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .work_req(work_req), .more_req(more_req),
        .cam_req(cam_req), .slot_o(slot_o), .sram_gnt(sram_gnt),
        .cam_load(cam_load), .waiting(waiting)
    );

    // {work, more, cam, ncyc, exp_cam, exp_wait, exp_sram}
    localparam int VW = 27;
    localparam int NV = 15;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'b0110, 4'b0000, 4'b0000, 3'd2, 4'b0010, 4'b0000, 4'b0000},
        {4'b0110, 4'b0000, 4'b0000, 3'd1, 4'b0010, 4'b0100, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000, 3'd3, 4'b0000, 4'b0100, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000, 3'd1, 4'b0100, 4'b0000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000, 3'd3, 4'b0100, 4'b0000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000, 3'd3, 4'b0000, 4'b0000, 4'b0010},
        {4'b0000, 4'b0010, 4'b0000, 3'd4, 4'b0000, 4'b0000, 4'b0010},
        {4'b0000, 4'b0010, 4'b0000, 3'd1, 4'b0000, 4'b0000, 4'b0100},
        {4'b1000, 4'b0000, 4'b0010, 3'd2, 4'b1000, 4'b0000, 4'b0000},
        {4'b1000, 4'b0000, 4'b0010, 3'd2, 4'b1000, 4'b0010, 4'b0100},
        {4'b0000, 4'b0100, 4'b0000, 3'd1, 4'b1000, 4'b0010, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000, 3'd2, 4'b0000, 4'b0010, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000, 3'd1, 4'b0010, 4'b0000, 4'b0100},
        {4'b0000, 4'b0000, 4'b0000, 3'd1, 4'b0010, 4'b0000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000, 3'd3, 4'b0000, 4'b0000, 4'b0000}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (edge %0d)", req, got, exp, t_edges);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            t_edges++;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        work_req = '0; more_req = '0; cam_req = '0;
        @(negedge clk);
        @(negedge clk);
        check("R3 cam_load in reset", {4'b0, cam_load}, 8'h00);
        check("R3 waiting in reset",  {4'b0, waiting},  8'h00);
        check("R1 slot in reset",     {6'b0, slot_o},   8'h00);
        rst_n = 1'b1;
        t_edges = 0;
    endtask

    initial begin
        #3_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        check("R3 sram_gnt after reset", {4'b0, sram_gnt}, 8'h00);

        // Vector walk: R4 R5 R6 R7 R8 transitions, cycle exact
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] r;
            r = VEC[v];
            work_req = r[26:23];
            more_req = r[22:19];
            cam_req  = r[18:15];
            step(int'(r[14:12]));
            check($sformatf("R4 R5 R6 R7 cam_load row %0d", v), {4'b0, cam_load}, {4'b0, r[11:8]});
            check($sformatf("R5 waiting row %0d", v),          {4'b0, waiting},  {4'b0, r[7:4]});
            check($sformatf("R8 sram_gnt row %0d", v),         {4'b0, sram_gnt}, {4'b0, r[3:0]});
            check($sformatf("R1 slot row %0d", v),             {6'b0, slot_o},   8'(t_edges % 4));
        end

        // R1: wrap of the slot counter
        work_req = '0; more_req = '0; cam_req = '0;
        while (slot_o != 2'd3) step(1);
        step(1);
        check("R1 slot wraps 3->0", {6'b0, slot_o}, 8'h00);

        // R3: reset mid-run clears everything
        work_req = 4'b0001;
        step(2);
        check("R6 engine 0 loading", {4'b0, cam_load}, 8'h01);
        do_reset();
        check("R3 cam_load after mid-run reset", {4'b0, cam_load}, 8'h00);

        // R2: work shown only outside engine 2's slot is ignored
        work_req = 4'b0100;
        step(2);              // edges in slots 0 and 1
        work_req = '0;
        step(2);              // edges in slots 2 and 3
        check("R2 off-slot work ignored cam", {4'b0, cam_load}, 8'h00);
        check("R2 off-slot work ignored wait", {4'b0, waiting}, 8'h00);

        // R4: more/cam requests have no effect in SLEEP
        more_req = 4'b1111; cam_req = 4'b1111;
        step(4);
        check("R4 sleep ignores more/cam", {4'b0, cam_load | waiting}, 8'h00);
        more_req = '0; cam_req = '0;

        // R10 R9 R5: four-way contention from a fresh reset
        do_reset();
        work_req = 4'b1111;
        begin
            int w3 = 0;
            int w3_max = 0;
            for (int e = 1; e <= 16; e++) begin
                step(1);
                if (waiting[3]) w3++; else w3 = 0;
                if (w3 > w3_max) w3_max = w3;
                if (e == 1)  check("R4 engine 0 loads first", {4'b0, cam_load}, 8'h01);
                if (e == 4)  check("R4 three engines parked", {4'b0, waiting}, 8'h0E);
                if (e == 6) begin
                    check("R5 engine 1 takes CAM", {4'b0, cam_load}, 8'h02);
                    check("R5 two still parked",   {4'b0, waiting},  8'h0C);
                end
                if (e == 11) check("R5 engine 2 takes CAM", {4'b0, cam_load}, 8'h04);
                if (e == 16) begin
                    check("R5 engine 3 takes CAM", {4'b0, cam_load}, 8'h08);
                    check("R9 single loader",      8'($countones(cam_load)), 8'd1);
                end
            end
            check("R10 longest wait is 12", 8'(w3_max), 8'd12);
        end
        work_req = '0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule